// File: doc/BRIEF.md
# Graphics DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a graphics DDR SDRAM and takes the device from power-on to a usable state. After a one-cycle `start` pulse it holds the DRAM reset low for a parameterised settling time. During that time it presents a clock-enable level that picks the address/control termination strength. It then raises reset and keeps clock enable at that level for a hold window before driving it high. A second settling time follows, during which the sequencer sends only deselects while the termination calibrates.

The command part comes next. The sequencer issues a precharge-all, an extended mode-register load that enables the DLL, and a base mode-register load that resets it. It waits out the DLL lock window, precharges all banks again and issues two auto refreshes. Each command is separated from the next by a programmable spacing filled with NOPs. When the last refresh spacing has run out, `init_done` goes high and stays high. The bus then carries NOPs so the normal-traffic scheduler can take over.

Every delay is a parameter. The two settling times are given in microseconds and are converted to cycles using the clock-frequency parameter `CLK_MHZ`. A variant parameter can add one register stage in front of all DRAM-facing outputs.

Top module: `gddr_init_seq`

## Requirements
- R1: In reset and in idle, `dram_res_n` is 0, `dram_cke` is 0, `dram_cs_n` is 1 and `init_done` is 0.
- R2: While `dram_res_n` is low, `dram_cs_n` is high on every cycle.
- R3: `dram_res_n` rises exactly `PWR_US*CLK_MHZ` cycles after the cycle in which `start` is taken (that cycle counts as 0, with outputs unregistered). From then on it stays high.
- R4: The termination select `odt_half` is captured with `start`. Clock enable equals its inverse while reset is low and at the reset rising edge (0 selects half strength, 1 selects full strength). It holds that level for `T_HOLD` cycles from the reset edge, is then 1, and never falls while reset is high.
- R5: The first command (anything other than deselect or NOP) appears exactly `T_HOLD + CAL_US*CLK_MHZ` cycles after reset rises. Before it, `dram_cs_n` is high.
- R6: Exactly six commands are issued, in this order, with the encoding {cs_n,ras_n,cas_n,we_n}:
  1. precharge-all, 0010 with address bit 8 = 1;
  2. extended mode load, 0000 with bank 3'b001 and address `EMR_CODE`;
  3. base mode load, 0000 with bank 3'b000 and address `MR_CODE`;
  4. precharge-all, 0010 with address bit 8 = 1;
  5. auto refresh, 0001;
  6. auto refresh, 0001.
- R7: The spacing from one command to the next is `T_RP` after a precharge, `T_MRD` after the extended load, `DLL_CYC` after the base load and `T_RFC` after the first refresh. Only NOP (0111) is sent in between.
- R8: `init_done` rises exactly `T_RFC` cycles after the second refresh. It then stays high with clock enable and reset high, and the bus carries only NOP.
- R9: Once the sequence has begun, further `start` pulses and changes of `odt_half` have no effect on timing or on the termination level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the power-up sequence (taken in idle only) |
| odt_half | input | 1 | 1 selects half-strength address/control termination |
| dram_res_n | output | 1 | DRAM reset |
| dram_cke | output | 1 | DRAM clock enable |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ba | output | BA_W | Bank address |
| dram_addr | output | ADDR_W | Address / mode opcode |
| init_done | output | 1 | Initialization complete, bus handed off |

## Verification
The sequence is run once with full-strength termination and once with half strength. Comparing the clock-enable level at the reset edge and through the hold window between the two runs separates a correct termination encoding from an inverted or ignored one. The half-strength run is also disturbed with extra `start` pulses and a flipped `odt_half` during the settling and DLL phases. A design that restarts or re-samples would shift the reset edge or the clock-enable level. In every run the cycle of each command is logged and compared with the sums of the spacing parameters, together with its code, bank and opcode. This catches a reordered command, a swapped mode opcode and an off-by-one in any single gap.

// File: rtl/gddr_init_pkg.sv
package gddr_init_pkg;

   typedef enum logic [4:0] {
      ST_IDLE,
      ST_PWR,
      ST_HOLD,
      ST_CAL,
      ST_PRE1,
      ST_WRP1,
      ST_EMR,
      ST_WMRD,
      ST_MR,
      ST_WDLL,
      ST_PRE2,
      ST_WRP2,
      ST_REF1,
      ST_WRFC1,
      ST_REF2,
      ST_WRFC2,
      ST_DONE
   } init_st_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_t;

   localparam cmd_t CMD_DESEL = 4'b1111;
   localparam cmd_t CMD_NOP   = 4'b0111;
   localparam cmd_t CMD_PRE   = 4'b0010;
   localparam cmd_t CMD_LMR   = 4'b0000;
   localparam cmd_t CMD_REF   = 4'b0001;

endpackage

// File: rtl/gddr_init_timer.sv
module gddr_init_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/gddr_init_fsm.sv
module gddr_init_fsm
   import gddr_init_pkg::*;
#(
   parameter int CW      = 8,
   parameter int PWR_CYC = 200,
   parameter int CAL_CYC = 200,
   parameter int T_HOLD  = 2,
   parameter int T_RP    = 3,
   parameter int T_MRD   = 4,
   parameter int DLL_CYC = 40,
   parameter int T_RFC   = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          odt_half,
   input  logic          tmr_zero,
   output logic          tmr_load,
   output logic [CW-1:0] tmr_val,
   output init_st_e      state,
   output logic          half_sel
);
   init_st_e cur_q, nxt;
   logic     half_q;

   // Cycles a state lasts, minus one; command states last one cycle.
   function automatic logic [CW-1:0] span(init_st_e s);
      case (s)
         ST_PWR:                     span = CW'(PWR_CYC - 1);
         ST_HOLD:                    span = CW'(T_HOLD - 1);
         ST_CAL:                     span = CW'(CAL_CYC - 1);
         ST_WRP1, ST_WRP2:           span = CW'(T_RP - 2);
         ST_WMRD:                    span = CW'(T_MRD - 2);
         ST_WDLL:                    span = CW'(DLL_CYC - 2);
         ST_WRFC1, ST_WRFC2:         span = CW'(T_RFC - 2);
         default:                    span = '0;
      endcase
   endfunction

   always_comb begin
      nxt = cur_q;
      case (cur_q)
         ST_IDLE: if (start) nxt = ST_PWR;
         ST_DONE: nxt = ST_DONE;
         default: if (tmr_zero) nxt = init_st_e'(cur_q + 5'd1);
      endcase
   end

   assign tmr_load = (nxt != cur_q);
   assign tmr_val  = span(nxt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= ST_IDLE;
         half_q <= 1'b0;
      end else begin
         cur_q <= nxt;
         if (cur_q == ST_IDLE && start) half_q <= odt_half;
      end
   end

   assign state    = cur_q;
   assign half_sel = half_q;
endmodule

// File: rtl/gddr_init_enc.sv
module gddr_init_enc
   import gddr_init_pkg::*;
#(
   parameter int          ADDR_W   = 12,
   parameter int          BA_W     = 3,
   parameter int          AP_BIT   = 8,
   parameter bit          REG_CMD  = 1'b0,
   parameter logic [11:0] EMR_CODE = 12'h044,
   parameter logic [11:0] MR_CODE  = 12'h171
) (
   input  logic              clk,
   input  logic              rst_n,
   input  init_st_e          state,
   input  logic              half_sel,
   output logic              res_n,
   output logic              cke,
   output cmd_t              cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              done
);
   localparam logic [BA_W-1:0]   BA_EMR  = BA_W'(1);
   localparam logic [BA_W-1:0]   BA_MR   = '0;
   localparam logic [ADDR_W-1:0] ADDR_AP = ADDR_W'(1) << AP_BIT;

   logic              res_c, cke_c, done_c;
   cmd_t              cmd_c;
   logic [BA_W-1:0]   ba_c;
   logic [ADDR_W-1:0] addr_c;

   always_comb begin
      res_c  = 1'b1;
      cke_c  = 1'b1;
      cmd_c  = CMD_NOP;
      ba_c   = '0;
      addr_c = '0;
      done_c = 1'b0;
      case (state)
         ST_IDLE: begin
            res_c = 1'b0; cke_c = 1'b0; cmd_c = CMD_DESEL;
         end
         ST_PWR: begin
            res_c = 1'b0; cke_c = ~half_sel; cmd_c = CMD_DESEL;
         end
         ST_HOLD: begin
            cke_c = ~half_sel; cmd_c = CMD_DESEL;
         end
         ST_CAL: cmd_c = CMD_DESEL;
         ST_PRE1, ST_PRE2: begin
            cmd_c = CMD_PRE; addr_c = ADDR_AP;
         end
         ST_EMR: begin
            cmd_c = CMD_LMR; ba_c = BA_EMR; addr_c = ADDR_W'(EMR_CODE);
         end
         ST_MR: begin
            cmd_c = CMD_LMR; ba_c = BA_MR; addr_c = ADDR_W'(MR_CODE);
         end
         ST_REF1, ST_REF2: cmd_c = CMD_REF;
         ST_DONE: done_c = 1'b1;
         default: cmd_c = CMD_NOP;
      endcase
   end

   generate
      if (REG_CMD) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res_n <= 1'b0; cke <= 1'b0; cmd <= CMD_DESEL;
               ba <= '0; addr <= '0; done <= 1'b0;
            end else begin
               res_n <= res_c; cke <= cke_c; cmd <= cmd_c;
               ba <= ba_c; addr <= addr_c; done <= done_c;
            end
         end
      end else begin : g_comb
         assign res_n = res_c;
         assign cke   = cke_c;
         assign cmd   = cmd_c;
         assign ba    = ba_c;
         assign addr  = addr_c;
         assign done  = done_c;
      end
   endgenerate
endmodule

// File: rtl/gddr_init_seq.sv
module gddr_init_seq
   import gddr_init_pkg::*;
#(
   parameter int          CLK_MHZ  = 500,
   parameter int          PWR_US   = 200,
   parameter int          CAL_US   = 200,
   parameter int          T_SETUP  = 2,
   parameter int          T_HOLD   = 4,
   parameter int          T_RP     = 12,
   parameter int          T_MRD    = 6,
   parameter int          DLL_CYC  = 20000,
   parameter int          T_RFC    = 40,
   parameter int          ADDR_W   = 12,
   parameter int          BA_W     = 3,
   parameter bit          REG_CMD  = 1'b0,
   parameter logic [11:0] EMR_CODE = 12'h044,
   parameter logic [11:0] MR_CODE  = 12'h171
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              odt_half,
   output logic              dram_res_n,
   output logic              dram_cke,
   output logic              dram_cs_n,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic [BA_W-1:0]   dram_ba,
   output logic [ADDR_W-1:0] dram_addr,
   output logic              init_done
);
   localparam int PWR_CYC = PWR_US * CLK_MHZ;
   localparam int CAL_CYC = CAL_US * CLK_MHZ;
   localparam int MAX_A   = (PWR_CYC > CAL_CYC) ? PWR_CYC : CAL_CYC;
   localparam int MAX_C   = (MAX_A > DLL_CYC) ? MAX_A : DLL_CYC;
   localparam int CW      = $clog2(MAX_C + 1);
   localparam int AP_BIT  = 8;

   generate
      if (PWR_CYC < T_SETUP || PWR_CYC < 1) begin : g_bad_pwr
         $error("power-up wait shorter than clock-enable setup");
      end
      if (CAL_CYC < 1 || T_HOLD < 1) begin : g_bad_cal
         $error("calibration wait and hold must be at least one cycle");
      end
      if (T_RP < 2 || T_MRD < 2 || T_RFC < 2 || DLL_CYC < 2) begin : g_bad_gap
         $error("command spacing must be at least two cycles");
      end
      if (ADDR_W <= AP_BIT || ADDR_W < 12 || BA_W < 2) begin : g_bad_bus
         $error("address or bank bus too narrow");
      end
   endgenerate

   init_st_e      state;
   logic          half_sel, tmr_load, tmr_zero;
   logic [CW-1:0] tmr_val;
   cmd_t          cmd;

   gddr_init_timer #(.CW(CW)) timer_i (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
   );

   gddr_init_fsm #(
      .CW(CW), .PWR_CYC(PWR_CYC), .CAL_CYC(CAL_CYC), .T_HOLD(T_HOLD),
      .T_RP(T_RP), .T_MRD(T_MRD), .DLL_CYC(DLL_CYC), .T_RFC(T_RFC)
   ) fsm_i (
      .clk(clk), .rst_n(rst_n), .start(start), .odt_half(odt_half),
      .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
      .state(state), .half_sel(half_sel)
   );

   gddr_init_enc #(
      .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT), .REG_CMD(REG_CMD),
      .EMR_CODE(EMR_CODE), .MR_CODE(MR_CODE)
   ) enc_i (
      .clk(clk), .rst_n(rst_n), .state(state), .half_sel(half_sel),
      .res_n(dram_res_n), .cke(dram_cke), .cmd(cmd), .ba(dram_ba),
      .addr(dram_addr), .done(init_done)
   );

   assign dram_cs_n  = cmd.cs_n;
   assign dram_ras_n = cmd.ras_n;
   assign dram_cas_n = cmd.cas_n;
   assign dram_we_n  = cmd.we_n;
endmodule

// File: rtl/gddr_init_seq_chk.sv
module gddr_init_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic dram_res_n,
   input logic dram_cke,
   input logic dram_cs_n,
   input logic dram_ras_n,
   input logic dram_cas_n,
   input logic dram_we_n,
   input logic init_done
);
   // R2: no command can reach the DRAM while its reset is held
   a_r2_desel_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_res_n |-> dram_cs_n);

   // R4: clock enable never drops once reset is released
   a_r4_cke_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
      dram_res_n |-> !$fell(dram_cke));

   // R8: completion is sticky
   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   // R8: after completion only NOP, with reset and clock enable high
   a_r8_nop_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (!dram_cs_n && dram_ras_n && dram_cas_n && dram_we_n
                     && dram_res_n && dram_cke));

   // R3: reset stays released once it has risen
   a_r3_res_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
      dram_res_n |=> dram_res_n);
endmodule

bind gddr_init_seq gddr_init_seq_chk chk_i (
   .clk(clk), .rst_n(rst_n), .dram_res_n(dram_res_n), .dram_cke(dram_cke),
   .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
   .dram_we_n(dram_we_n), .init_done(init_done)
);

// File: tb/gddr_init_seq_tb.sv
module gddr_init_seq_tb_top;
   localparam int          CLK_PERIOD = 10;
   localparam int          MHZ      = 1;
   localparam int          PWR_US   = 200;
   localparam int          CAL_US   = 150;
   localparam int          HOLD     = 3;
   localparam int          RP       = 3;
   localparam int          MRD      = 4;
   localparam int          DLL      = 40;
   localparam int          RFC      = 6;
   localparam logic [11:0] EMR      = 12'h0A5;
   localparam logic [11:0] MR       = 12'h35C;

   logic        clk = 1'b0;
   logic        rst_n, start, odt_half;
   logic        res_n, cke, cs_n, ras_n, cas_n, we_n, done;
   logic [2:0]  ba;
   logic [11:0] addr;
   int          n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gddr_init_seq #(
      .CLK_MHZ(MHZ), .PWR_US(PWR_US), .CAL_US(CAL_US), .T_SETUP(2), .T_HOLD(HOLD),
      .T_RP(RP), .T_MRD(MRD), .DLL_CYC(DLL), .T_RFC(RFC),
      .ADDR_W(12), .BA_W(3), .REG_CMD(1'b0), .EMR_CODE(EMR), .MR_CODE(MR)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .odt_half(odt_half),
      .dram_res_n(res_n), .dram_cke(cke), .dram_cs_n(cs_n), .dram_ras_n(ras_n),
      .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_ba(ba), .dram_addr(addr),
      .init_done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      start = 1'b0; odt_half = 1'b0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      do_reset();
      repeat (4) @(negedge clk);   // idle without start
      chk(res_n == 1'b0, "R1 res_n", int'(res_n), 0);
      chk(cke == 1'b0,   "R1 cke",   int'(cke), 0);
      chk(cs_n == 1'b1,  "R1 cs_n",  int'(cs_n), 1);
      chk(done == 1'b0,  "R1 done",  int'(done), 0);
   endtask

   // Runs one full init; disturb exercises R9
   task automatic t_sequence(input bit half, input bit disturb);
      int  res_cyc = -1, done_cyc = -1, n_cmd = 0, bad_cs = 0, bad_gap = 0;
      int  cyc_l[8];
      logic [3:0]  code_l[8];
      logic [2:0]  ba_l[8];
      logic [11:0] addr_l[8];
      int  e0, e1, e2, e3, e4, e5;
      bit  sel = ~half;
      do_reset();
      odt_half = half; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int cyc = 0; cyc < 2000; cyc++) begin
         if (disturb) begin
            if (cyc == 40 || cyc == 300 || cyc == 380) begin start = 1'b1; odt_half = ~half; end
            else begin start = 1'b0; if (cyc == 45) odt_half = half; end
         end
         if (!res_n && !cs_n) bad_cs++;
         if (res_n && res_cyc < 0) begin
            res_cyc = cyc;
            chk(cke == sel, "R4 cke at reset edge", int'(cke), int'(sel));
         end
         if (!res_n && cyc > 0 && cke != sel) bad_cs++;
         if (res_cyc >= 0 && cyc == res_cyc + HOLD - 1)
            chk(cke == sel, "R4 cke end of hold", int'(cke), int'(sel));
         if (res_cyc >= 0 && cyc == res_cyc + HOLD)
            chk(cke == 1'b1, "R4 cke high after hold", int'(cke), 1);
         if (!cs_n && {ras_n, cas_n, we_n} != 3'b111) begin
            if (n_cmd < 8) begin
               cyc_l[n_cmd] = cyc; code_l[n_cmd] = {cs_n, ras_n, cas_n, we_n};
               ba_l[n_cmd] = ba; addr_l[n_cmd] = addr;
            end
            n_cmd++;
         end else if (n_cmd > 0 && !done && cs_n) bad_gap++;
         if (done && done_cyc < 0) done_cyc = cyc;
         if (done_cyc >= 0 && cyc == done_cyc + 6) break;
         @(negedge clk);
      end
      start = 1'b0; odt_half = half;
      chk(bad_cs == 0, "R2 cs_n high and cke at select while reset low", bad_cs, 0);
      chk(res_cyc == PWR_US * MHZ, "R3/R9 reset rise cycle", res_cyc, PWR_US * MHZ);
      chk(n_cmd == 6, "R6 command count", n_cmd, 6);
      chk(bad_gap == 0, "R7 NOP in gaps", bad_gap, 0);
      if (n_cmd == 6) begin
         e0 = res_cyc + HOLD + CAL_US * MHZ;
         e1 = e0 + RP; e2 = e1 + MRD; e3 = e2 + DLL; e4 = e3 + RP; e5 = e4 + RFC;
         chk(cyc_l[0] == e0, "R5 first command cycle", cyc_l[0], e0);
         chk(code_l[0] == 4'b0010 && addr_l[0][8], "R6 precharge-all 1", int'(code_l[0]), 2);
         chk(code_l[1] == 4'b0000 && ba_l[1] == 3'b001, "R6 extended load bank", int'(ba_l[1]), 1);
         chk(addr_l[1] == EMR, "R6 extended opcode", int'(addr_l[1]), int'(EMR));
         chk(code_l[2] == 4'b0000 && ba_l[2] == 3'b000, "R6 base load bank", int'(ba_l[2]), 0);
         chk(addr_l[2] == MR, "R6 base opcode", int'(addr_l[2]), int'(MR));
         chk(code_l[3] == 4'b0010 && addr_l[3][8], "R6 precharge-all 2", int'(code_l[3]), 2);
         chk(code_l[4] == 4'b0001 && code_l[5] == 4'b0001, "R6 refresh codes",
             int'(code_l[5]), 1);
         chk(cyc_l[1] == e1, "R7 spacing after precharge", cyc_l[1], e1);
         chk(cyc_l[2] == e2, "R7 spacing after extended load", cyc_l[2], e2);
         chk(cyc_l[3] == e3, "R7 DLL lock spacing", cyc_l[3], e3);
         chk(cyc_l[4] == e4, "R7 spacing after second precharge", cyc_l[4], e4);
         chk(cyc_l[5] == e5, "R7 refresh spacing", cyc_l[5], e5);
         chk(done_cyc == e5 + RFC, "R8 done cycle", done_cyc, e5 + RFC);
      end
      chk(done == 1'b1 && !cs_n && ras_n && cas_n && we_n && cke,
          "R8 done holds with NOP", int'(done), 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset_state();
      t_sequence(1'b0, 1'b0);
      t_sequence(1'b1, 1'b0);
      t_sequence(1'b1, 1'b1);
      t_sequence(1'b0, 1'b1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule